// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Core

A single-port synchronous memory whose data phase always trails its command phase by exactly one clock. Address, direction, byte selects and the chip-select qualifiers are registered on an edge. The matching data then moves during the following cycle. This means a read may sit directly behind a write, or a write behind a read, with no idle bus cycle between them. Reads are flow-through: the word is looked up combinationally during the data cycle and placed on the bus without an output register. Write data is captured at the end of its data cycle into a one-entry holding register. It is committed to the array on the next active edge, and reads that hit the holding register are forwarded from it.

A two-bit burst counter lets one loaded address serve four consecutive accesses in linear order, wrapping inside an aligned group of four. An active-low clock enable freezes the whole pipeline. The bus drive enable is produced inside the block, and an asynchronous output-enable input can force it off at any time.

Top module: `zbt_sram`

## Requirements
- R1: After reset no operation is pending and `dq_oe_o` is low; an advance issued before any load starts nothing.
- R2: A read loaded in cycle n places the addressed word on `dq_o` with `dq_oe_o` high during cycle n+1, provided `oe_n_i` is low.
- R3: A write loaded in cycle n takes its data from `dq_i` at the clock edge that ends cycle n+1, and a later read of that address returns it.
- R4: Byte lane k occupies bits [9k+8:9k] of the word, and a write updates only lanes whose `byte_sel_i` bit is 1.
- R5: Reads and writes to the same address may alternate on consecutive cycles, and each read returns the data of the write loaded just before it.
- R6: While `cen_n_i` is high, all other synchronous inputs are ignored, all internal state holds, and `dq_o`/`dq_oe_o` keep their values for any number of cycles.
- R7: A new operation is loaded only when `adv_i`=0 and `ce0_n_i`=0, `ce1_i`=1, `ce2_n_i`=0; otherwise nothing new starts, but an access already loaded still completes its data cycle.
- R8: `dq_oe_o` is low in the cycle after a deselect or after a write is loaded.
- R9: `oe_n_i` high forces `dq_oe_o` low in the same cycle, whatever the pipeline holds.
- R10: `adv_i`=1 repeats the direction of the last load at the next burst address: the low two address bits count up from the loaded value modulo 4 while the upper bits stay fixed. After a load that started nothing, an advance starts nothing.
- R11: `byte_sel_i` is sampled together with each operation, including operations started by an advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_n_i | input | 1 | Clock enable, active low; high stalls the block |
| addr_i | input | ADDR_W | Word address for a load |
| wr_i | input | 1 | 1 = write, 0 = read |
| byte_sel_i | input | LANES | Per-lane write select, active high |
| ce0_n_i | input | 1 | Chip select, active low |
| ce1_i | input | 1 | Chip select, active high |
| ce2_n_i | input | 1 | Chip select, active low |
| adv_i | input | 1 | 1 = advance burst, 0 = load new address |
| oe_n_i | input | 1 | Asynchronous output enable, active low |
| dq_i | input | LANES*LANE_W | Write data from the bus |
| dq_o | output | LANES*LANE_W | Read data to the bus |
| dq_oe_o | output | 1 | Bus drive enable |

## Verification
The hardest case to reach is a read whose data cycle falls while a same-address write still sits in the holding register. That case is made harder by partial byte selects and by clock-enable stalls that hold the holding register uncommitted. Directed sequences alternate writes and reads to one address, and they insert multi-cycle stalls in the middle, with the stalled cycles carrying conflicting commands. A random phase over a 16-word window then mixes bursts, deselects, stalls and byte selects, checking every cycle against a behavioural model.

// File: rtl/zbt_sram_pkg.sv
package zbt_sram_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  localparam int unsigned BURST_W = 2;
endpackage

// File: rtl/zbt_ctrl.sv
module zbt_ctrl
  import zbt_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cen_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [LANES-1:0]  byte_sel_i,
  input  logic              ce0_n_i,
  input  logic              ce1_i,
  input  logic              ce2_n_i,
  input  logic              adv_i,
  output op_e               pend_op_o,
  output logic [ADDR_W-1:0] pend_addr_o,
  output logic [LANES-1:0]  pend_sel_o
);
  localparam int unsigned BW = BURST_W;

  logic              sel;
  logic              burst_act_q, burst_wr_q;
  logic [ADDR_W-1:0] base_q;
  logic [BW-1:0]     off_q, off_nx;
  op_e               nx_op, pend_op_q;
  logic [ADDR_W-1:0] nx_addr, pend_addr_q;
  logic [LANES-1:0]  pend_sel_q;

  assign sel    = ~ce0_n_i & ce1_i & ~ce2_n_i;
  assign off_nx = off_q + 1'b1;

  always_comb begin
    if (!adv_i) begin
      nx_op   = sel ? (wr_i ? OP_WRITE : OP_READ) : OP_NONE;
      nx_addr = addr_i;
    end else begin
      nx_op   = burst_act_q ? (burst_wr_q ? OP_WRITE : OP_READ) : OP_NONE;
      nx_addr = {base_q[ADDR_W-1:BW], base_q[BW-1:0] + off_nx};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_op_q   <= OP_NONE;
      pend_addr_q <= '0;
      pend_sel_q  <= '0;
      burst_act_q <= 1'b0;
      burst_wr_q  <= 1'b0;
      base_q      <= '0;
      off_q       <= '0;
    end else if (!cen_n_i) begin
      pend_op_q   <= nx_op;
      pend_addr_q <= nx_addr;
      pend_sel_q  <= byte_sel_i;
      if (!adv_i) begin
        burst_act_q <= sel;
        burst_wr_q  <= wr_i;
        base_q      <= addr_i;
        off_q       <= '0;
      end else begin
        off_q <= off_nx;
      end
    end
  end

  assign pend_op_o   = pend_op_q;
  assign pend_addr_o = pend_addr_q;
  assign pend_sel_o  = pend_sel_q;

  a_r6_stall_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cen_n_i |=> $stable(pend_op_q) && $stable(pend_addr_q) && $stable(pend_sel_q));

  a_r7_no_start_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_n_i && !adv_i && !(~ce0_n_i & ce1_i & ~ce2_n_i)) |=> pend_op_q == OP_NONE);

  a_r10_burst_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_n_i && adv_i && pend_op_q != OP_NONE) |=>
      pend_op_q != OP_NONE &&
      pend_addr_q[BW-1:0] == BW'($past(pend_addr_q[BW-1:0]) + 1'b1) &&
      pend_addr_q[ADDR_W-1:BW] == $past(pend_addr_q[ADDR_W-1:BW]));
endmodule

// File: rtl/zbt_wbuf.sv
module zbt_wbuf
  import zbt_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cen_n_i,
  input  op_e               pend_op_i,
  input  logic [ADDR_W-1:0] pend_addr_i,
  input  logic [LANES-1:0]  pend_sel_i,
  input  logic [W-1:0]      dq_i,
  input  logic [W-1:0]      rd_array_i,
  output logic              commit_en_o,
  output logic [ADDR_W-1:0] commit_addr_o,
  output logic [LANES-1:0]  commit_sel_o,
  output logic [W-1:0]      commit_data_o,
  output logic [W-1:0]      rd_data_o
);
  logic              wb_v_q;
  logic [ADDR_W-1:0] wb_addr_q;
  logic [LANES-1:0]  wb_sel_q;
  logic [W-1:0]      wb_data_q;
  logic              hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_v_q    <= 1'b0;
      wb_addr_q <= '0;
      wb_sel_q  <= '0;
      wb_data_q <= '0;
    end else if (!cen_n_i) begin
      wb_v_q <= (pend_op_i == OP_WRITE);
      if (pend_op_i == OP_WRITE) begin
        wb_addr_q <= pend_addr_i;
        wb_sel_q  <= pend_sel_i;
        wb_data_q <= dq_i;
      end
    end
  end

  assign commit_en_o   = wb_v_q & ~cen_n_i;
  assign commit_addr_o = wb_addr_q;
  assign commit_sel_o  = wb_sel_q;
  assign commit_data_o = wb_data_q;

  // forward uncommitted lanes to a read of the same word
  assign hit = wb_v_q && (wb_addr_q == pend_addr_i);

  for (genvar l = 0; l < LANES; l++) begin : g_byp
    assign rd_data_o[l*LANE_W +: LANE_W] = (hit && wb_sel_q[l])
        ? wb_data_q[l*LANE_W +: LANE_W] : rd_array_i[l*LANE_W +: LANE_W];
  end

  a_r3_write_captured: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_n_i && pend_op_i == OP_WRITE) |=> wb_v_q && wb_addr_q == $past(pend_addr_i)
      && wb_sel_q == $past(pend_sel_i));
endmodule

// File: rtl/zbt_array.sv
module zbt_array #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [LANES-1:0]  lane_we_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [W-1:0]      rdata_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && lane_we_i[l]) mem[waddr_i] <= wdata_i[l*LANE_W +: LANE_W];
    end

    assign rdata_o[l*LANE_W +: LANE_W] = mem[raddr_i];
  end
endmodule

// File: rtl/zbt_sram.sv
module zbt_sram
  import zbt_sram_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 9,
  localparam int unsigned ADDR_W = $clog2(DEPTH),
  localparam int unsigned W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cen_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [LANES-1:0]  byte_sel_i,
  input  logic              ce0_n_i,
  input  logic              ce1_i,
  input  logic              ce2_n_i,
  input  logic              adv_i,
  input  logic              oe_n_i,
  input  logic [W-1:0]      dq_i,
  output logic [W-1:0]      dq_o,
  output logic              dq_oe_o
);
  op_e               pend_op;
  logic [ADDR_W-1:0] pend_addr;
  logic [LANES-1:0]  pend_sel;
  logic              commit_en;
  logic [ADDR_W-1:0] commit_addr;
  logic [LANES-1:0]  commit_sel;
  logic [W-1:0]      commit_data;
  logic [W-1:0]      rd_array, rd_data;

  zbt_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk_i, .rst_ni, .cen_n_i, .addr_i, .wr_i, .byte_sel_i,
    .ce0_n_i, .ce1_i, .ce2_n_i, .adv_i,
    .pend_op_o(pend_op), .pend_addr_o(pend_addr), .pend_sel_o(pend_sel)
  );

  zbt_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
    .clk_i, .rst_ni, .cen_n_i,
    .pend_op_i(pend_op), .pend_addr_i(pend_addr), .pend_sel_i(pend_sel),
    .dq_i, .rd_array_i(rd_array),
    .commit_en_o(commit_en), .commit_addr_o(commit_addr),
    .commit_sel_o(commit_sel), .commit_data_o(commit_data),
    .rd_data_o(rd_data)
  );

  zbt_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i, .we_i(commit_en), .waddr_i(commit_addr), .lane_we_i(commit_sel),
    .wdata_i(commit_data), .raddr_i(pend_addr), .rdata_o(rd_array)
  );

  assign dq_oe_o = (pend_op == OP_READ) & ~oe_n_i;
  assign dq_o    = dq_oe_o ? rd_data : '0;

  a_r8_hiz_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_n_i && !adv_i && !ce0_n_i && ce1_i && !ce2_n_i && wr_i) |=> !dq_oe_o);

  a_r8_hiz_after_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cen_n_i && !adv_i && !(!ce0_n_i && ce1_i && !ce2_n_i)) |=> !dq_oe_o);

  a_r9_oe_forces_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_n_i |-> !dq_oe_o);
endmodule

// File: tb/zbt_sram_test.sv
module zbt_sram_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 256;
  localparam int LANES  = 2;
  localparam int LANE_W = 9;
  localparam int AW = $clog2(DEPTH);
  localparam int W  = LANES * LANE_W;
  localparam logic [2:0] SEL = 3'b010; // {ce0_n, ce1, ce2_n}

  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic cen_n_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic wr_i = 1'b0;
  logic [LANES-1:0] byte_sel_i = '0;
  logic ce0_n_i = 1'b1, ce1_i = 1'b0, ce2_n_i = 1'b1;
  logic adv_i = 1'b0;
  logic oe_n_i = 1'b0;
  logic [W-1:0] dq_i = '0;
  logic [W-1:0] dq_o;
  logic dq_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference state
  logic [W-1:0] ref_mem [DEPTH];
  bit m_pv, m_pw, m_ba, m_bw;
  int m_pa, m_base, m_off;
  logic [LANES-1:0] m_ps;

  zbt_sram #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(string tag, bit cen_n, logic [2:0] ce, bit adv, bit wr,
                      int addr, logic [LANES-1:0] bsel, bit oe_n);
    bit exp_oe;
    bit sel;
    cen_n_i = cen_n; {ce0_n_i, ce1_i, ce2_n_i} = ce; adv_i = adv; wr_i = wr;
    addr_i = AW'(addr); byte_sel_i = bsel; oe_n_i = oe_n;
    dq_i = W'($urandom);
    #1;
    exp_oe = m_pv && !m_pw && !oe_n;
    check(tag, W'(dq_oe_o), W'(exp_oe));
    if (exp_oe) check(tag, dq_o, ref_mem[m_pa]);
    @(posedge clk_i);
    if (!cen_n) begin
      if (m_pv && m_pw)
        for (int l = 0; l < LANES; l++)
          if (m_ps[l]) ref_mem[m_pa][l*LANE_W +: LANE_W] = dq_i[l*LANE_W +: LANE_W];
      sel = (ce == SEL);
      if (!adv) begin
        m_pv = sel; m_pw = wr; m_pa = addr;
        m_ba = sel; m_bw = wr; m_base = addr; m_off = 0;
      end else begin
        m_off = (m_off + 1) % 4;
        m_pv = m_ba; m_pw = m_bw;
        m_pa = (m_base & ~3) | ((m_base + m_off) & 3);
      end
      m_ps = bsel;
    end
    @(negedge clk_i);
  endtask

  task automatic idle(string tag);
    step(tag, 1'b0, 3'b110, 1'b0, 1'b0, 0, '0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    m_pv = 0; m_pw = 0; m_ba = 0; m_bw = 0; m_pa = 0; m_base = 0; m_off = 0; m_ps = '0;
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1: idle after reset, and an advance before any load starts nothing
    check("R1", W'(dq_oe_o), '0);
    step("R1", 1'b0, SEL, 1'b1, 1'b0, 0, '0, 1'b0);
    step("R1", 1'b0, SEL, 1'b1, 1'b0, 0, '0, 1'b0);

    // R3/R10: fill words 0..15 with burst writes
    for (int g = 0; g < 4; g++) begin
      step("R3", 1'b0, SEL, 1'b0, 1'b1, g*4, 2'b11, 1'b0);
      for (int k = 0; k < 3; k++) step("R10", 1'b0, SEL, 1'b1, 1'b0, 0, 2'b11, 1'b0);
    end
    idle("R3");

    // R2: flow-through reads
    for (int a = 0; a < 16; a++) step("R2", 1'b0, SEL, 1'b0, 1'b0, a, '0, 1'b0);
    idle("R2");

    // R5: alternate write/read on one address
    for (int i = 0; i < 8; i++) step("R5", 1'b0, SEL, 1'b0, i[0] == 1'b0, 5, 2'b11, 1'b0);
    idle("R5");

    // R4/R11: partial lane writes
    step("R4", 1'b0, SEL, 1'b0, 1'b1, 9, 2'b01, 1'b0);
    step("R4", 1'b0, SEL, 1'b0, 1'b0, 9, 2'b11, 1'b0);
    step("R4", 1'b0, SEL, 1'b0, 1'b1, 9, 2'b10, 1'b0);
    step("R4", 1'b0, SEL, 1'b0, 1'b0, 9, 2'b00, 1'b0);
    step("R11", 1'b0, SEL, 1'b0, 1'b1, 9, 2'b00, 1'b0);
    step("R11", 1'b0, SEL, 1'b0, 1'b0, 9, 2'b11, 1'b0);
    step("R11", 1'b0, SEL, 1'b0, 1'b1, 12, 2'b11, 1'b0);
    step("R11", 1'b0, SEL, 1'b1, 1'b0, 0, 2'b01, 1'b0);
    step("R11", 1'b0, SEL, 1'b1, 1'b0, 0, 2'b10, 1'b0);
    step("R11", 1'b0, SEL, 1'b0, 1'b0, 13, 2'b00, 1'b0);
    step("R11", 1'b0, SEL, 1'b0, 1'b0, 14, 2'b00, 1'b0);
    idle("R4");

    // R6: stalls in the middle of write-read-write with conflicting inputs
    step("R6", 1'b0, SEL, 1'b0, 1'b1, 3, 2'b11, 1'b0);
    for (int s = 0; s < 3; s++) step("R6", 1'b1, SEL, 1'b0, 1'b1, 4, 2'b11, 1'b0);
    step("R6", 1'b0, SEL, 1'b0, 1'b0, 3, 2'b11, 1'b0);
    for (int s = 0; s < 3; s++) step("R6", 1'b1, 3'b110, 1'b1, 1'b1, 3, 2'b11, 1'b0);
    step("R6", 1'b0, SEL, 1'b0, 1'b1, 3, 2'b10, 1'b0);
    step("R6", 1'b1, SEL, 1'b0, 1'b0, 4, 2'b01, 1'b0);
    step("R6", 1'b0, SEL, 1'b0, 1'b0, 3, 2'b11, 1'b0);
    step("R6", 1'b0, SEL, 1'b0, 1'b0, 4, 2'b11, 1'b0);
    idle("R6");

    // R7/R8: pending read survives deselect; bus off after deselect or write
    step("R7", 1'b0, SEL, 1'b0, 1'b0, 2, '0, 1'b0);
    step("R7", 1'b0, 3'b000, 1'b0, 1'b0, 7, '0, 1'b0);
    step("R8", 1'b0, 3'b011, 1'b0, 1'b0, 7, '0, 1'b0);
    step("R8", 1'b0, SEL, 1'b0, 1'b0, 2, '0, 1'b0);
    step("R8", 1'b0, SEL, 1'b0, 1'b1, 2, 2'b11, 1'b0);
    step("R8", 1'b0, SEL, 1'b0, 1'b0, 2, '0, 1'b0);
    idle("R8");

    // R9: output enable overrides a read data cycle
    step("R9", 1'b0, SEL, 1'b0, 1'b0, 7, '0, 1'b0);
    step("R9", 1'b0, SEL, 1'b0, 1'b0, 8, '0, 1'b1);
    step("R9", 1'b0, 3'b110, 1'b0, 1'b0, 0, '0, 1'b0);

    // R10: advance after a deselect load; burst wrap from word 6
    step("R10", 1'b0, 3'b011, 1'b0, 1'b0, 6, '0, 1'b0);
    step("R10", 1'b0, SEL, 1'b1, 1'b0, 6, '0, 1'b0);
    step("R10", 1'b0, SEL, 1'b1, 1'b0, 6, '0, 1'b0);
    step("R10", 1'b0, SEL, 1'b0, 1'b0, 6, '0, 1'b0);
    for (int k = 0; k < 4; k++) step("R10", 1'b0, SEL, 1'b1, 1'b0, 0, '0, 1'b0);
    idle("R10");

    // R5/R6/R10: random mix over words 0..15
    for (int n = 0; n < 600; n++) begin
      logic [2:0] ce;
      ce = ($urandom_range(7) == 0) ? 3'($urandom) : SEL;
      step("R5", $urandom_range(7) == 0, ce, $urandom_range(2) == 0, 1'($urandom),
           $urandom_range(15), 2'($urandom), $urandom_range(9) == 0);
    end
    idle("R5");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule